// File: doc/BRIEF.md
# Dual-Mode Serial Character Receiver

This block turns a single serial input line into characters. A mode input picks one of two ways of finding the bits. In oversampled mode the block runs from a clock enable at sixteen times the baud rate. A falling line becomes a start bit only after it stays low long enough. Each later bit is then read at the middle of its bit period. In clocked mode the block reads the line on every rising edge of an external baud clock. A low level seen while idle starts a character at once.

The character length is 5 to 8 bits, received least significant bit first. Parity can be off, even, odd, forced low or forced high. One or two stop bits follow. When the last stop bit has been read, the block shows the character right-aligned, a parity error flag and a framing error flag, and pulses a valid strobe for one clock. The line and the baud clock each pass through a two-flop synchronizer before any decision is made.

Top module: `serial_char_rx`

## Requirements
- R1: After reset the block waits for a start bit, and rx_valid, rx_data, parity_err and frame_err are all 0.
- R2: With mode_sync=0, a low line is taken as a start bit only on the 8th consecutive tick16 pulse that finds it low. A low run of 7 ticks or fewer produces no character.
- R3: With mode_sync=0, the first data bit is read at tick 24 counted from the first low tick (tick 0), and each later bit 16 ticks after the one before it. Bits are therefore read at the middle of each 16-tick period.
- R4: Data bits arrive least significant bit first. len_sel selects the length (0=5, 1=6, 2=7, 3=8 bits). rx_data holds the character in its low bits, with the unused high bits at 0.
- R5: par_mode codes are 0=none, 1=even (data plus parity bit hold an even count of ones), 2=odd, 3=parity bit must be 0, 4=parity bit must be 1, and 5 to 7 act as none. parity_err is 1 when a parity bit is present and disagrees with the code. It is 0 when there is no parity bit.
- R6: two_stop=1 reads two stop bits and two_stop=0 reads one. frame_err is 1 when any stop bit read is low.
- R7: With mode_sync=1, the line is read on each rising edge of bclk. A low level read while idle starts a character with no duration check, and each following rising edge reads the next bit.
- R8: rx_valid is high for exactly one clock per character. rx_data, parity_err and frame_err change only together with it and hold their values until the next character.
- R9: With mode_sync=0, bclk has no effect. With mode_sync=1, tick16 has no effect.
- R10: After the last stop bit is read, the block goes back to waiting for a start bit, so characters may follow one another with no extra gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sync | input | 1 | 0: oversampled mode, 1: mode clocked by bclk |
| tick16 | input | 1 | Clock enable at 16x the baud rate (oversampled mode) |
| bclk | input | 1 | External baud clock (clocked mode), synchronized inside |
| rx_line | input | 1 | Serial data line, idle high |
| len_sel | input | 2 | Character length code (0..3 = 5..8 bits) |
| par_mode | input | 3 | Parity mode code |
| two_stop | input | 1 | 1: two stop bits, 0: one |
| rx_data | output | 8 | Received character, right-aligned |
| rx_valid | output | 1 | One-clock strobe when a character is complete |
| parity_err | output | 1 | Parity mismatch on the last character |
| frame_err | output | 1 | Low stop bit on the last character |

## Verification
In oversampled mode the bench inverts the first and last three ticks of every data and parity bit. A receiver that reads off the middle of the bit, or whose first read is not at tick 24, then returns a wrong character. Low pulses of exactly 7 and exactly 8 ticks test the start threshold: an off-by-one design either invents a character from the 7-tick glitch or misses the 8-tick start and the all-ones character that follows it. Every parity code is paired with a correct and a flipped parity bit, and frames with a low first or second stop bit catch a design that checks only one stop bit. Frames with 5 and 6 bits catch wrong alignment or leftover high bits. bclk keeps running during oversampled frames and tick16 during clocked ones, so a design that mixes the two sources goes wrong.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DATA  = 3'd1,
    ST_PAR   = 3'd2,
    ST_STOP1 = 3'd3,
    ST_STOP2 = 3'd4
  } rx_state_t;

  localparam logic [2:0] PAR_NONE = 3'd0;
  localparam logic [2:0] PAR_EVEN = 3'd1;
  localparam logic [2:0] PAR_ODD  = 3'd2;
  localparam logic [2:0] PAR_ZERO = 3'd3;
  localparam logic [2:0] PAR_ONE  = 3'd4;

  function automatic logic parity_used(input logic [2:0] m);
    return (m == PAR_EVEN) || (m == PAR_ODD) || (m == PAR_ZERO) || (m == PAR_ONE);
  endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= RST_VAL[i];
        stab <= RST_VAL[i];
      end else begin
        meta <= d[i];
        stab <= meta;
      end
    end
    assign q[i] = stab;
  end
endmodule

// File: rtl/serial_rx_sampler.sv
module serial_rx_sampler #(
  parameter int OVS       = 16,
  parameter int START_MIN = 8,
  parameter int FIRST_OFS = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sync,
  input  logic tick,
  input  logic line_s,
  input  logic bclk_s,
  input  logic busy,
  output logic start_acc,
  output logic bit_stb,
  output logic bit_val
);
  localparam int LOAD  = FIRST_OFS - START_MIN + 1;
  localparam int TMAX  = (LOAD > OVS) ? LOAD : OVS;
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam int LOW_W = $clog2(START_MIN);

  logic             bclk_q;
  logic             bclk_rise;
  logic [LOW_W-1:0] low_run;
  logic [CNT_W-1:0] mid_timer;
  logic             async_start, sync_start, async_stb, sync_stb;

  assign bclk_rise = bclk_s & ~bclk_q;

  always_comb begin
    async_start = !mode_sync && !busy && tick && !line_s &&
                  (low_run == LOW_W'(START_MIN - 1));
    sync_start  = mode_sync && !busy && bclk_rise && !line_s;
    async_stb   = !mode_sync && busy && tick && (mid_timer == CNT_W'(1));
    sync_stb    = mode_sync && busy && bclk_rise;
  end

  assign start_acc = async_start | sync_start;
  assign bit_stb   = async_stb | sync_stb;
  assign bit_val   = line_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q    <= 1'b0;
      low_run   <= '0;
      mid_timer <= '0;
    end else begin
      bclk_q <= bclk_s;
      if (busy || mode_sync) begin
        low_run <= '0;
      end else if (tick) begin
        if (line_s || async_start) low_run <= '0;
        else                       low_run <= low_run + 1'b1;
      end
      if (async_start) begin
        mid_timer <= CNT_W'(LOAD);
      end else if (!mode_sync && busy && tick) begin
        if (mid_timer == CNT_W'(1)) mid_timer <= CNT_W'(OVS);
        else                        mid_timer <= mid_timer - 1'b1;
      end
    end
  end

  AST_START_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |-> !line_s);  // R2
  AST_ASYNC_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sync && !tick) |-> !(start_acc || bit_stb));  // R9
  AST_SYNC_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sync && (start_acc || bit_stb)) |-> $rose(bclk_s));  // R7
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int MIN_BITS = 5,
  parameter int LEN_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_acc,
  input  logic                bit_stb,
  input  logic                bit_val,
  input  logic [LEN_W-1:0]    len_sel,
  input  logic [2:0]          par_mode,
  input  logic                two_stop,
  output logic                busy,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_valid,
  output logic                parity_err,
  output logic                frame_err
);
  localparam int BC_W = $clog2(MAX_BITS);
  localparam int SPAN = MAX_BITS - MIN_BITS;

  function automatic logic [BC_W-1:0] last_index(input logic [LEN_W-1:0] sel);
    return BC_W'(MIN_BITS - 1) + BC_W'(sel);
  endfunction

  function automatic logic [MAX_BITS-1:0] right_align(input logic [MAX_BITS-1:0] sh,
                                                      input logic [LEN_W-1:0] sel);
    return sh >> (SPAN - int'(sel));
  endfunction

  function automatic logic parity_expect(input logic [MAX_BITS-1:0] d,
                                         input logic [2:0] m);
    case (m)
      PAR_EVEN: return ^d;
      PAR_ODD:  return ~^d;
      PAR_ONE:  return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

  rx_state_t           state;
  logic [BC_W-1:0]     bit_idx;
  logic [MAX_BITS-1:0] shreg;
  logic                par_bit, stop_bad;
  logic                frame_done, done_ferr;
  logic [MAX_BITS-1:0] data_now;

  assign busy     = (state != ST_IDLE);
  assign data_now = right_align(shreg, len_sel);

  always_comb begin
    frame_done = 1'b0;
    done_ferr  = 1'b0;
    if (bit_stb) begin
      if (state == ST_STOP1 && !two_stop) begin
        frame_done = 1'b1;
        done_ferr  = !bit_val;
      end else if (state == ST_STOP2) begin
        frame_done = 1'b1;
        done_ferr  = stop_bad | !bit_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bit_idx    <= '0;
      shreg      <= '0;
      par_bit    <= 1'b0;
      stop_bad   <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      rx_valid <= frame_done;
      if (frame_done) begin
        rx_data    <= data_now;
        frame_err  <= done_ferr;
        parity_err <= parity_used(par_mode) &&
                      (par_bit != parity_expect(data_now, par_mode));
      end
      case (state)
        ST_IDLE: if (start_acc) begin
          state    <= ST_DATA;
          bit_idx  <= '0;
          stop_bad <= 1'b0;
        end
        ST_DATA: if (bit_stb) begin
          shreg <= {bit_val, shreg[MAX_BITS-1:1]};
          if (bit_idx == last_index(len_sel))
            state <= parity_used(par_mode) ? ST_PAR : ST_STOP1;
          else
            bit_idx <= bit_idx + 1'b1;
        end
        ST_PAR: if (bit_stb) begin
          par_bit <= bit_val;
          state   <= ST_STOP1;
        end
        ST_STOP1: if (bit_stb) begin
          if (two_stop) begin
            stop_bad <= !bit_val;
            state    <= ST_STOP2;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_STOP2: if (bit_stb) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_VALID_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);  // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_data) && $stable(frame_err) && $stable(parity_err)));  // R8
  AST_VALID_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(bit_stb));  // R6
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |-> (state == ST_IDLE));  // R10
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx #(
  parameter int MAX_BITS  = 8,
  parameter int MIN_BITS  = 5,
  parameter int OVS       = 16,
  parameter int START_MIN = 8,
  parameter int FIRST_OFS = 24,
  localparam int LEN_W    = $clog2(MAX_BITS - MIN_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_sync,
  input  logic                tick16,
  input  logic                bclk,
  input  logic                rx_line,
  input  logic [LEN_W-1:0]    len_sel,
  input  logic [2:0]          par_mode,
  input  logic                two_stop,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_valid,
  output logic                parity_err,
  output logic                frame_err
);
  logic [1:0] raw_in, sync_out;
  logic       line_s, bclk_s;
  logic       start_acc, bit_stb, bit_val, busy;

  assign raw_in = {bclk, rx_line};
  assign line_s = sync_out[0];
  assign bclk_s = sync_out[1];

  serial_rx_sync #(.WIDTH(2), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  serial_rx_sampler #(.OVS(OVS), .START_MIN(START_MIN), .FIRST_OFS(FIRST_OFS)) u_smp (
    .clk(clk), .rst_n(rst_n), .mode_sync(mode_sync), .tick(tick16),
    .line_s(line_s), .bclk_s(bclk_s), .busy(busy),
    .start_acc(start_acc), .bit_stb(bit_stb), .bit_val(bit_val)
  );

  serial_rx_frame #(.MAX_BITS(MAX_BITS), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .bit_stb(bit_stb),
    .bit_val(bit_val), .len_sel(len_sel), .par_mode(par_mode), .two_stop(two_stop),
    .busy(busy), .rx_data(rx_data), .rx_valid(rx_valid),
    .parity_err(parity_err), .frame_err(frame_err)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rx_valid);  // R1
endmodule

// File: tb/sim_serial_char_rx.sv
module sim_serial_char_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sync = 1'b0;
  logic rx = 1'b1;
  logic [1:0] len_sel = 2'd3;
  logic [2:0] par_mode = 3'd0;
  logic two_stop = 1'b0;
  logic [7:0] rx_data;
  logic rx_valid, parity_err, frame_err;
  logic [1:0] tcnt = '0;
  logic [2:0] bcnt = '0;
  logic tick16, bclk;

  int nchecks = 0;
  int nfail = 0;
  int nvalid = 0;
  bit prev_valid = 0;
  logic [7:0] last_d = '0;

  typedef struct { logic [7:0] d; logic pe; logic fe; string tag; } exp_t;
  exp_t sbq[$];
  exp_t e;

  always #4 clk = ~clk;  // 125 MHz
  always @(negedge clk) begin
    tcnt <= tcnt + 1'b1;
    bcnt <= bcnt + 1'b1;
  end
  assign tick16 = (tcnt == 2'd0);
  assign bclk   = bcnt[2];

  serial_char_rx u0 (
    .clk(clk), .rst_n(rst_n), .mode_sync(mode_sync), .tick16(tick16), .bclk(bclk),
    .rx_line(rx), .len_sel(len_sel), .par_mode(par_mode), .two_stop(two_stop),
    .rx_data(rx_data), .rx_valid(rx_valid), .parity_err(parity_err), .frame_err(frame_err)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic ref_parity(input logic [7:0] d, input int len, input logic [2:0] m);
    int ones = 0;
    for (int i = 0; i < len; i++) ones += d[i];
    case (m)
      3'd1: return (ones % 2) == 1;
      3'd2: return (ones % 2) == 0;
      3'd4: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit has_parity(input logic [2:0] m);
    return m >= 3'd1 && m <= 3'd4;
  endfunction

  task automatic push_exp(input logic [7:0] d, input int len, input logic [2:0] m, input bit two,
                          input bit flip, input bit s1, input bit s2, input string tag);
    exp_t x;
    x.d = d & (8'hFF >> (8 - len));
    x.pe = has_parity(m) && flip;
    x.fe = !s1 || (two && !s2);
    x.tag = tag;
    sbq.push_back(x);
  endtask

  task automatic hold(input logic v, input int nticks);
    rx = v;
    repeat (nticks * 4) @(negedge clk);
  endtask

  task automatic noisy_bit(input logic b);
    hold(!b, 3); hold(b, 10); hold(!b, 3);
  endtask

  task automatic stop_bit_async(input bit s);
    if (s) hold(1'b1, 16);
    else begin hold(1'b0, 12); hold(1'b1, 4); end
  endtask

  task automatic send_async(input logic [7:0] d, input int len, input logic [2:0] m, input bit two,
                            input bit flip, input bit s1, input bit s2, input string tag);
    len_sel = 2'(len - 5); par_mode = m; two_stop = two;
    push_exp(d, len, m, two, flip, s1, s2, tag);
    hold(1'b0, 16);
    for (int i = 0; i < len; i++) noisy_bit(d[i]);
    if (has_parity(m)) noisy_bit(ref_parity(d, len, m) ^ flip);
    stop_bit_async(s1);
    if (two) stop_bit_async(s2);
    hold(1'b1, 8);
  endtask

  task automatic sync_put(input logic v);
    @(negedge bclk);
    rx = v;
  endtask

  task automatic send_sync(input logic [7:0] d, input int len, input logic [2:0] m, input bit two,
                           input bit flip, input bit s1, input bit s2, input string tag);
    len_sel = 2'(len - 5); par_mode = m; two_stop = two;
    push_exp(d, len, m, two, flip, s1, s2, tag);
    sync_put(1'b0);
    for (int i = 0; i < len; i++) sync_put(d[i]);
    if (has_parity(m)) sync_put(ref_parity(d, len, m) ^ flip);
    sync_put(s1);
    if (two) sync_put(s2);
    sync_put(1'b1);
    sync_put(1'b1);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        nvalid++;
        chk(!prev_valid, "R8", "valid longer than one clock", 1, 0);
        if (sbq.size() == 0) begin
          chk(1'b0, "R2", "character with no start expected", {24'd0, rx_data}, 0);
        end else begin
          e = sbq.pop_front();
          chk(rx_data == e.d, e.tag, "data", {24'd0, rx_data}, {24'd0, e.d});
          chk(parity_err == e.pe, "R5", "parity_err", parity_err, e.pe);
          chk(frame_err == e.fe, "R6", "frame_err", frame_err, e.fe);
          last_d = e.d;
        end
      end
      prev_valid = rx_valid;
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchecks++;
    nfail++;
    $display("FAIL R10 watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    int vcount;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(rx_valid == 0 && rx_data == 0 && parity_err == 0 && frame_err == 0,
        "R1", "outputs in reset", {rx_valid, parity_err, frame_err, rx_data}, 0);
    rst_n = 1'b1;
    hold(1'b1, 20);
    chk(rx_valid == 0 && rx_data == 0, "R1", "idle after reset", {rx_valid, rx_data}, 0);

    // oversampled mode; bclk keeps toggling throughout (R9)
    send_async(8'hA5, 8, 3'd1, 0, 0, 1, 1, "R3");   // 8 bits, even parity, 1 stop
    send_async(8'h13, 5, 3'd0, 0, 0, 1, 1, "R4");
    send_async(8'hDA, 6, 3'd2, 0, 1, 1, 1, "R4");   // odd, flipped parity
    send_async(8'hFF, 7, 3'd3, 0, 0, 1, 1, "R4");   // forced 0
    send_async(8'h81, 8, 3'd4, 0, 1, 1, 1, "R5");   // forced 1, flipped
    send_async(8'h3C, 8, 3'd6, 0, 0, 1, 1, "R5");   // code 6 acts as none
    send_async(8'h66, 8, 3'd0, 1, 0, 1, 0, "R6");   // second stop low
    send_async(8'h99, 8, 3'd0, 0, 0, 0, 1, "R6");   // single stop low
    send_async(8'h42, 8, 3'd2, 1, 0, 1, 1, "R9");

    // R2: 7-tick low pulse must be ignored
    vcount = nvalid;
    hold(1'b0, 7);
    hold(1'b1, 200);
    chk(nvalid == vcount, "R2", "7-tick low gave a character", nvalid - vcount, 0);
    // R2: 8-tick low pulse starts a character of all ones
    len_sel = 2'd3; par_mode = 3'd0; two_stop = 1'b0;
    push_exp(8'hFF, 8, 3'd0, 0, 0, 1, 1, "R2");
    hold(1'b0, 8);
    hold(1'b1, 200);
    chk(nvalid == vcount + 1, "R2", "8-tick low gave no character", nvalid - vcount, 1);

    // R8: result held between characters
    repeat (50) @(negedge clk);
    chk(rx_data == last_d, "R8", "data not held", {24'd0, rx_data}, {24'd0, last_d});

    // clocked mode; tick16 keeps running (R9)
    mode_sync = 1'b1;
    repeat (20) @(negedge clk);
    send_sync(8'hC3, 8, 3'd1, 0, 0, 1, 1, "R7");
    send_sync(8'h2E, 6, 3'd2, 1, 1, 1, 0, "R9");
    send_sync(8'h0F, 5, 3'd0, 0, 0, 0, 1, "R7");
    send_sync(8'hB4, 8, 3'd4, 1, 0, 0, 1, "R7");

    // R10: back to oversampled mode, characters back to back
    mode_sync = 1'b0;
    hold(1'b1, 20);
    send_async(8'h7E, 8, 3'd1, 0, 0, 1, 1, "R10");
    send_async(8'h55, 8, 3'd0, 0, 0, 1, 1, "R10");

    repeat (300) @(negedge clk);
    chk(sbq.size() == 0, "R10", "characters missing", sbq.size(), 0);
    finish_run();
  end
endmodule